// File: doc/BRIEF.md
# Token-Ring Adapter Host Glue Registers

This block is the host-side glue between a byte/word host I/O window and the register interface of a token-ring controller. Two control registers decide what the window shows. It either reaches the controller's word registers or a two-page identification ROM. The control registers also drive the controller reset, a page-extension select line, the ring-speed pin and the interrupt enable. A level-sensitive interrupt latch and a cable-type output register complete the block. The controller is represented by a small word register file. The ROM is a constant array built from parameters and from three configuration bytes supplied on an input port.

The host address has five bits. When bit 4 is 0, offsets 0 to 15 select the glue registers: control register A at offset 0, control register B at offset 1, the cable register at offset 7, and zero for all other offsets. When bit 4 is 1, address bits 2..0 are a byte offset into the window, and bit 3 is ignored there. Reads are combinational. Writes take effect at the clock edge on which `hst_wr` is high. A glue register read returns its value in the low byte.

Top module: `tr_host_glue`

## Requirements
- R1: After reset, control registers A and B and the cable register read 0, `ctrl_rst_n` is 0, `host_irq` is 0, and the window shows ROM page 0, so window offset 0 reads 0x004D.
- R2: While control register A bit 2 (window select) is 0, the window shows the ROM. Host writes into the window then do not change any controller register.
- R3: With window select 0 and control register A bit 3 (ROM page) 0, window bytes 0..7 read 0x4D, the card type, the card revision, `cfg_pos[7:0]`, `cfg_pos[15:8]`, `cfg_pos[23:16]`, 0, 0. Each value is zero-extended to 16 bits.
- R4: With window select 0 and ROM page 1, window byte 0 reads 0, bytes 1 to 6 read the 48-bit station address with the most significant byte first, and byte 7 reads 0.
- R5: With window select 1, the controller register index is {control register B bit 1, address bits 2..1}. A word access transfers all 16 bits. A byte access uses the low byte of the register when address bit 0 is 0 and the high byte when it is 1, with the byte carried on data bits 7..0.
- R6: `ctrl_rst_n` follows control register B bit 0. While that bit is 0, every controller register is cleared at each clock, and host writes to controller registers are lost.
- R7: `speed_16` follows control register B bit 2: 1 selects 16 Mb/s and 0 selects 4 Mb/s.
- R8: A high `ctrl_irq` at a clock edge sets the interrupt latch. The latch stays set when `ctrl_irq` falls. It reads as control register A bit 7, and `host_irq` is the latch gated by control register B bit 3 (interrupt enable).
- R9: A write that changes interrupt enable from 0 to 1 clears the latch at that edge, and the clear takes priority over a set in the same cycle. If `ctrl_irq` is still high, the latch sets again at the next edge.
- R10: Cable register bit 0 drives `cable_utp`: 1 selects UTP and 0 selects STP.
- R11: Control registers read back their contents. Control register A bit 7 is read-only, and writes to it neither set nor clear the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | 5 | Host offset; bit 4 selects the window |
| hst_wr | input | 1 | Host write strobe |
| hst_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data (combinational) |
| ctrl_irq | input | 1 | Interrupt request from the controller |
| cfg_pos | input | 24 | Three configuration bytes mirrored in ROM page 0 |
| ctrl_rst_n | output | 1 | Controller reset, active low |
| speed_16 | output | 1 | Ring speed select |
| cable_utp | output | 1 | Cable type select |
| host_irq | output | 1 | Host interrupt line |

## Verification
The hardest situation to reach is the acknowledge race. The controller keeps its request high while the host toggles the enable bit, so the latch must be clear for exactly one cycle and then set again. The stimulus holds `ctrl_irq` high across a disable-then-enable write pair and samples the latch just after the enabling edge and one cycle later. A second hard case is a window write that is dropped while the ROM is mapped. Its effect can only be seen after the controller registers are remapped and read back.

// File: rtl/tr_glue_pkg.sv
`timescale 1ns/1ps
// Shared constants for the adapter glue: bit positions and host offsets.
// Assumes byte-wide glue registers and a 16-bit controller register file.
package tr_glue_pkg;
    // Control register A
    localparam int CA_WINSEL = 2;
    localparam int CA_PAGE   = 3;
    // Control register B
    localparam int CB_NRST   = 0;
    localparam int CB_XSEL   = 1;
    localparam int CB_SPEED  = 2;
    localparam int CB_IEN    = 3;
    // Glue register offsets (window bit clear)
    localparam logic [3:0] OFS_CA    = 4'd0;
    localparam logic [3:0] OFS_CB    = 4'd1;
    localparam logic [3:0] OFS_CABLE = 4'd7;

    typedef enum logic [1:0] {
        SP_GLUE = 2'd0,
        SP_CTRL = 2'd1,
        SP_ROM  = 2'd2
    } space_e;
endpackage

// File: rtl/tr_glue_ctl.sv
`timescale 1ns/1ps
// Glue control registers, cable register and interrupt latch.
// Assumes the caller qualifies wr with "glue space"; offsets are 4 bits.
module tr_glue_ctl
    import tr_glue_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [3:0] ofs,
    input  logic [7:0] wdata,
    input  logic       ctrl_irq,
    output logic [7:0] ca_img,
    output logic [7:0] cb_img,
    output logic       cable_q,
    output logic       host_irq
);
    logic [6:0] ca_r;
    logic [7:0] cb_r;
    logic       cable_r;
    logic       latch_r;
    logic       wr_a, wr_b, wr_c, ack;

    // Decode which glue register this write targets and detect acknowledge
    always_comb begin
        wr_a = wr && (ofs == OFS_CA);
        wr_b = wr && (ofs == OFS_CB);
        wr_c = wr && (ofs == OFS_CABLE);
        ack  = wr_b && wdata[CB_IEN] && !cb_r[CB_IEN];
    end

    // Control register A storage (bit 7 is the latch, not stored here)
    always_ff @(posedge clk) begin
        if (!rst_n)    ca_r <= '0;
        else if (wr_a) ca_r <= wdata[6:0];
    end

    // Control register B storage
    always_ff @(posedge clk) begin
        if (!rst_n)    cb_r <= '0;
        else if (wr_b) cb_r <= wdata;
    end

    // Cable type register
    always_ff @(posedge clk) begin
        if (!rst_n)    cable_r <= 1'b0;
        else if (wr_c) cable_r <= wdata[0];
    end

    // Level-sensitive interrupt latch; enable rising edge clears it
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_r <= 1'b0;
        else if (ack)      latch_r <= 1'b0;
        else if (ctrl_irq) latch_r <= 1'b1;
    end

    // Read images and pin outputs
    always_comb begin
        ca_img   = {latch_r, ca_r};
        cb_img   = cb_r;
        cable_q  = cable_r;
        host_irq = latch_r && cb_r[CB_IEN];
    end

    // R8
    irq_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_irq && !ack) |=> ca_img[7]);
    // R8
    latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ca_img[7] && !ack) |=> ca_img[7]);
    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && wdata[CB_IEN] && !cb_img[CB_IEN]) |=> !ca_img[7]);
    // R11
    sintr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && !ca_img[7] && !ctrl_irq) |=> !ca_img[7]);
    // R7
    speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_b |=> $stable(cb_img[CB_SPEED]));
    // R10
    cable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_c |=> $stable(cable_q));
endmodule

// File: rtl/tr_glue_idrom.sv
`timescale 1ns/1ps
// Two-page identification ROM, byte wide, eight bytes per page.
// Page 0: id, type, revision, three config bytes; page 1: station address.
module tr_glue_idrom #(
    parameter logic [7:0]  MAN_ID       = 8'h4D,
    parameter logic [7:0]  CARD_TYPE    = 8'h08,
    parameter logic [7:0]  CARD_REV     = 8'h02,
    parameter logic [47:0] STATION_ADDR = 48'h0000F6A1B2C3
) (
    input  logic        page,
    input  logic [2:0]  idx,
    input  logic [23:0] cfg,
    output logic [7:0]  dout
);
    // Select the ROM byte for the current page and offset
    always_comb begin
        dout = 8'h00;
        if (!page) begin
            case (idx)
                3'd0:    dout = MAN_ID;
                3'd1:    dout = CARD_TYPE;
                3'd2:    dout = CARD_REV;
                3'd3:    dout = cfg[7:0];
                3'd4:    dout = cfg[15:8];
                3'd5:    dout = cfg[23:16];
                default: dout = 8'h00;
            endcase
        end else begin
            case (idx)
                3'd1:    dout = STATION_ADDR[47:40];
                3'd2:    dout = STATION_ADDR[39:32];
                3'd3:    dout = STATION_ADDR[31:24];
                3'd4:    dout = STATION_ADDR[23:16];
                3'd5:    dout = STATION_ADDR[15:8];
                3'd6:    dout = STATION_ADDR[7:0];
                default: dout = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/tr_glue_sif_stub.sv
`timescale 1ns/1ps
// Stand-in for the controller's word registers.
// Assumes writes are pre-qualified; registers clear while run is low.
module tr_glue_sif_stub #(
    parameter int SEL_W = 3,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             we,
    input  logic             word,
    input  logic             lane,
    input  logic [SEL_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    localparam int NREG = 1 << SEL_W;
    localparam int HB   = DW / 2;

    logic [DW-1:0] rf [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit;
        // Does this write target register g
        always_comb hit = we && (idx == SEL_W'(g));

        // One controller register: cleared in reset, word or lane write
        always_ff @(posedge clk) begin
            if (!rst_n || !run)   rf[g] <= '0;
            else if (hit && word) rf[g] <= wdata;
            else if (hit && lane) rf[g][DW-1:HB] <= wdata[HB-1:0];
            else if (hit)         rf[g][HB-1:0]  <= wdata[HB-1:0];
        end

        // R6
        held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> (rf[g] == '0));
    end

    // Word read port
    always_comb rdata = rf[idx];
endmodule

// File: rtl/tr_host_glue.sv
`timescale 1ns/1ps
// Top of the adapter host glue: address decode, read mux, controller stub.
// Assumes a single-cycle host bus; reads are combinational.
module tr_host_glue
    import tr_glue_pkg::*;
#(
    parameter int          HOST_SEL_BITS = 2,
    parameter logic [7:0]  MAN_ID        = 8'h4D,
    parameter logic [7:0]  CARD_TYPE     = 8'h08,
    parameter logic [7:0]  CARD_REV      = 8'h02,
    parameter logic [47:0] STATION_ADDR  = 48'h0000F6A1B2C3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [HOST_SEL_BITS+2:0] hst_addr,
    input  logic                     hst_wr,
    input  logic                     hst_word,
    input  logic [15:0]              hst_wdata,
    output logic [15:0]              hst_rdata,
    input  logic                     ctrl_irq,
    input  logic [23:0]              cfg_pos,
    output logic                     ctrl_rst_n,
    output logic                     speed_16,
    output logic                     cable_utp,
    output logic                     host_irq
);
    localparam int WIN_BITS = HOST_SEL_BITS + 1;
    localparam int SEL_W    = HOST_SEL_BITS + 1;
    localparam int WIN_BIT  = HOST_SEL_BITS + 2;

    space_e           space;
    logic [7:0]       ca_img, cb_img, rom_byte;
    logic             cable_q;
    logic [SEL_W-1:0] sif_idx;
    logic [15:0]      sif_word;
    logic             glue_wr, sif_we;

    // Decode the target space and the controller register index
    always_comb begin
        if (!hst_addr[WIN_BIT])   space = SP_GLUE;
        else if (ca_img[CA_WINSEL]) space = SP_CTRL;
        else                      space = SP_ROM;
        sif_idx = {cb_img[CB_XSEL], hst_addr[HOST_SEL_BITS:1]};
        glue_wr = hst_wr && (space == SP_GLUE);
        sif_we  = hst_wr && (space == SP_CTRL);
    end

    tr_glue_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (glue_wr),
        .ofs      (hst_addr[3:0]),
        .wdata    (hst_wdata[7:0]),
        .ctrl_irq (ctrl_irq),
        .ca_img   (ca_img),
        .cb_img   (cb_img),
        .cable_q  (cable_q),
        .host_irq (host_irq)
    );

    tr_glue_idrom #(
        .MAN_ID       (MAN_ID),
        .CARD_TYPE    (CARD_TYPE),
        .CARD_REV     (CARD_REV),
        .STATION_ADDR (STATION_ADDR)
    ) u_rom (
        .page (ca_img[CA_PAGE]),
        .idx  (hst_addr[WIN_BITS-1:0]),
        .cfg  (cfg_pos),
        .dout (rom_byte)
    );

    tr_glue_sif_stub #(
        .SEL_W (SEL_W),
        .DW    (16)
    ) u_sif (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cb_img[CB_NRST]),
        .we    (sif_we),
        .word  (hst_word),
        .lane  (hst_addr[0]),
        .idx   (sif_idx),
        .wdata (hst_wdata),
        .rdata (sif_word)
    );

    // Host read multiplexer
    always_comb begin
        hst_rdata = 16'h0000;
        case (space)
            SP_GLUE: begin
                case (hst_addr[3:0])
                    OFS_CA:    hst_rdata = {8'h00, ca_img};
                    OFS_CB:    hst_rdata = {8'h00, cb_img};
                    OFS_CABLE: hst_rdata = {15'h0000, cable_q};
                    default:   hst_rdata = 16'h0000;
                endcase
            end
            SP_CTRL: begin
                if (hst_word)         hst_rdata = sif_word;
                else if (hst_addr[0]) hst_rdata = {8'h00, sif_word[15:8]};
                else                  hst_rdata = {8'h00, sif_word[7:0]};
            end
            default: hst_rdata = {8'h00, rom_byte};
        endcase
    end

    // Pin outputs driven from control register B and the cable register
    always_comb begin
        ctrl_rst_n = cb_img[CB_NRST];
        speed_16   = cb_img[CB_SPEED];
        cable_utp  = cable_q;
    end

    // R3
    rom_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_addr[WIN_BIT] && !ca_img[CA_WINSEL] && !ca_img[CA_PAGE]
         && hst_addr[WIN_BITS-1:0] == '0) |-> (hst_rdata == {8'h00, MAN_ID}));
    // R2
    rom_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_addr[WIN_BIT] && !ca_img[CA_WINSEL]) |-> (hst_rdata[15:8] == 8'h00));
endmodule

// File: tb/tr_host_glue_bench.sv
`timescale 1ns/1ps
module tr_host_glue_bench;
    localparam logic [7:0]  B_TYPE = 8'h08;
    localparam logic [7:0]  B_REV  = 8'h02;
    localparam logic [47:0] B_STA  = 48'h0000F6A1B2C3;
    localparam logic [23:0] B_CFG  = 24'h5A3C81;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  hst_addr = '0;
    logic        hst_wr = 1'b0;
    logic        hst_word = 1'b0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        ctrl_irq = 1'b0;
    logic [23:0] cfg_pos = B_CFG;
    logic        ctrl_rst_n, speed_16, cable_utp, host_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tr_host_glue #(
        .CARD_TYPE (B_TYPE), .CARD_REV (B_REV), .STATION_ADDR (B_STA)
    ) u_tr_host_glue (
        .clk (clk), .rst_n (rst_n), .hst_addr (hst_addr), .hst_wr (hst_wr),
        .hst_word (hst_word), .hst_wdata (hst_wdata), .hst_rdata (hst_rdata),
        .ctrl_irq (ctrl_irq), .cfg_pos (cfg_pos), .ctrl_rst_n (ctrl_rst_n),
        .speed_16 (speed_16), .cable_utp (cable_utp), .host_irq (host_irq)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_a, m_b;
    logic        m_cable, m_latch;
    logic [15:0] m_sif [8];

    function automatic logic [7:0] m_rom(input logic pg, input int i);
        if (!pg) begin
            if (i == 0) return 8'h4D;
            if (i == 1) return B_TYPE;
            if (i == 2) return B_REV;
            if (i >= 3 && i <= 5) return 8'((B_CFG >> (8 * (i - 3))) & 24'hFF);
            return 8'h00;
        end
        if (i >= 1 && i <= 6) return 8'((B_STA >> (8 * (6 - i))) & 48'hFF);
        return 8'h00;
    endfunction

    function automatic logic [15:0] m_read(input logic [4:0] a, input logic w);
        int k;
        if (!a[4]) begin
            if (a[3:0] == 0) return {8'h00, m_latch, m_a[6:0]};
            if (a[3:0] == 1) return {8'h00, m_b};
            if (a[3:0] == 7) return {15'h0, m_cable};
            return 16'h0;
        end
        if (m_a[2]) begin
            k = m_b[1] * 4 + int'(a[2:1]);
            if (w) return m_sif[k];
            return a[0] ? {8'h00, m_sif[k][15:8]} : {8'h00, m_sif[k][7:0]};
        end
        return {8'h00, m_rom(m_a[3], int'(a[2:0]))};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_cable = 0; m_latch = 0;
            for (int i = 0; i < 8; i++) m_sif[i] = 0;
        end else begin
            logic ackn;
            ackn = hst_wr && !hst_addr[4] && hst_addr[3:0] == 1
                   && hst_wdata[3] && !m_b[3];
            if (!m_b[0]) begin
                for (int i = 0; i < 8; i++) m_sif[i] = 0;
            end else if (hst_wr && hst_addr[4] && m_a[2]) begin
                int k;
                k = m_b[1] * 4 + int'(hst_addr[2:1]);
                if (hst_word) m_sif[k] = hst_wdata;
                else if (hst_addr[0]) m_sif[k][15:8] = hst_wdata[7:0];
                else m_sif[k][7:0] = hst_wdata[7:0];
            end
            if (ackn) m_latch = 0;
            else if (ctrl_irq) m_latch = 1;
            if (hst_wr && !hst_addr[4]) begin
                if (hst_addr[3:0] == 0) m_a = {1'b0, hst_wdata[6:0]};
                if (hst_addr[3:0] == 1) m_b = hst_wdata[7:0];
                if (hst_addr[3:0] == 7) m_cable = hst_wdata[0];
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            string t;
            if (!hst_addr[4]) t = "R11";
            else if (m_a[2]) t = "R5";
            else t = m_a[3] ? "R4" : "R3";
            chk(t, hst_rdata, m_read(hst_addr, hst_word));
            chk("R6", {15'h0, ctrl_rst_n}, {15'h0, m_b[0]});
            chk("R7", {15'h0, speed_16}, {15'h0, m_b[2]});
            chk("R10", {15'h0, cable_utp}, {15'h0, m_cable});
            chk("R8", {15'h0, host_irq}, {15'h0, m_latch & m_b[3]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic w);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_word = w; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [4:0] a, input logic w,
                      input logic [15:0] exp);
        hst_addr = a; hst_word = w;
        #1;
        chk(tag, hst_rdata, exp);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd("R1", 5'h00, 0, 16'h0000);
        rd("R1", 5'h01, 0, 16'h0000);
        rd("R1", 5'h07, 0, 16'h0000);
        chk("R1", {15'h0, ctrl_rst_n}, 16'h0);
        chk("R1", {15'h0, host_irq}, 16'h0);
        rd("R1", 5'h10, 0, 16'h004D);
        // R3 page zero
        for (int i = 0; i < 8; i++)
            rd("R3", 5'(16 + i), 0, {8'h00, m_rom(1'b0, i)});
        rd("R3", 5'h13, 0, 16'h0081);
        // R4 page one
        wr(5'h00, 16'h0008, 0);
        for (int i = 0; i < 8; i++)
            rd("R4", 5'(16 + i), 0, {8'h00, m_rom(1'b1, i)});
        rd("R4", 5'h11, 0, 16'h0000);
        rd("R4", 5'h16, 0, 16'h00C3);
        // R6 writes lost while controller reset held
        wr(5'h00, 16'h0004, 0);
        wr(5'h10, 16'h1234, 1);
        rd("R6", 5'h10, 1, 16'h0000);
        // R5 release reset and fill both pages
        wr(5'h01, 16'h0001, 0);
        chk("R6", {15'h0, ctrl_rst_n}, 16'h1);
        for (int i = 0; i < 4; i++) wr(5'(16 + 2 * i), 16'(16'hA000 + i), 1);
        wr(5'h01, 16'h0003, 0);
        for (int i = 0; i < 4; i++) wr(5'(16 + 2 * i), 16'(16'hB100 + i), 1);
        rd("R5", 5'h12, 1, 16'hB101);
        wr(5'h01, 16'h0001, 0);
        rd("R5", 5'h16, 1, 16'hA003);
        wr(5'h11, 16'h00EE, 0);
        rd("R5", 5'h10, 1, 16'hEE00);
        rd("R5", 5'h11, 0, 16'h00EE);
        wr(5'h12, 16'h0077, 0);
        rd("R5", 5'h12, 1, 16'hA077);
        // R2 window write dropped while ROM mapped
        wr(5'h00, 16'h0000, 0);
        wr(5'h10, 16'hBEEF, 1);
        rd("R2", 5'h10, 1, 16'h004D);
        wr(5'h00, 16'h0004, 0);
        rd("R2", 5'h10, 1, 16'hEE00);
        // R7 speed
        wr(5'h01, 16'h0005, 0);
        chk("R7", {15'h0, speed_16}, 16'h1);
        wr(5'h01, 16'h0001, 0);
        chk("R7", {15'h0, speed_16}, 16'h0);
        // R10 cable
        wr(5'h07, 16'h0001, 0);
        chk("R10", {15'h0, cable_utp}, 16'h1);
        rd("R10", 5'h07, 0, 16'h0001);
        wr(5'h07, 16'h0000, 0);
        chk("R10", {15'h0, cable_utp}, 16'h0);
        // R8 latch while masked, then visible when enabled
        @(negedge clk); ctrl_irq = 1'b1;
        @(negedge clk); ctrl_irq = 1'b0;
        rd("R8", 5'h00, 0, 16'h0084);
        chk("R8", {15'h0, host_irq}, 16'h0);
        wr(5'h01, 16'h0009, 0);
        rd("R9", 5'h00, 0, 16'h0004);
        @(negedge clk); ctrl_irq = 1'b1;
        @(negedge clk); ctrl_irq = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", {15'h0, host_irq}, 16'h1);
        // R11 write to read-only bit keeps latch
        wr(5'h00, 16'h0004, 0);
        rd("R11", 5'h00, 0, 16'h0084);
        // R9 toggle acknowledge with request removed
        wr(5'h01, 16'h0001, 0);
        chk("R9", {15'h0, host_irq}, 16'h0);
        rd("R9", 5'h00, 0, 16'h0084);
        wr(5'h01, 16'h0009, 0);
        rd("R9", 5'h00, 0, 16'h0004);
        // R9 toggle with request still high
        @(negedge clk); ctrl_irq = 1'b1;
        wr(5'h01, 16'h0001, 0);
        hst_addr = 5'h01; hst_wdata = 16'h0009; hst_word = 0; hst_wr = 1'b1;
        @(negedge clk); hst_wr = 1'b0;
        rd("R9", 5'h00, 0, 16'h0004);
        @(negedge clk);
        rd("R9", 5'h00, 0, 16'h0084);
        chk("R9", {15'h0, host_irq}, 16'h1);
        ctrl_irq = 1'b0;
        // R11 read-back and read-only bit
        wr(5'h00, 16'h00FF, 0);
        rd("R11", 5'h00, 0, 16'h00FF);
        wr(5'h01, 16'h0001, 0);
        wr(5'h01, 16'h0009, 0);
        wr(5'h00, 16'h0080, 0);
        rd("R11", 5'h00, 0, 16'h0000);
        wr(5'h01, 16'h00F1, 0);
        rd("R11", 5'h01, 0, 16'h00F1);
        // R6 reasserting controller reset clears registers
        wr(5'h00, 16'h0004, 0);
        wr(5'h01, 16'h0000, 0);
        wr(5'h01, 16'h0001, 0);
        rd("R6", 5'h16, 1, 16'h0000);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule